// File: doc/BRIEF.md
# Clock-Generating Serial Word Receiver with Stall and Early Stop

This block is the receiving side of a synchronous serial link on which it is the clock master. While its halt input is low, it divides the system clock down to a shift clock and drives that clock out. It samples an NRZ data line once per shift-clock period, most significant bit first, and assembles 8-bit words in a shift register. Each finished word moves into a one-entry receive buffer. An active-low ready flag and an optional one-cycle interrupt pulse tell the host that the buffer holds data.

Reception runs without gaps from one word to the next for as long as the host empties the buffer in time. If a word finishes while the buffer still holds unread data, the block stops the shift clock at its idle level and keeps the new word in the shift register. When the host reads the buffer, the held word moves in and clocking resumes. Raising halt in the middle of a word stops the clock at once. The bits received so far go into the buffer, left-aligned, so that a message can end with a short word.

Top module: `sync_rx_stall`

## Requirements
- R1: After reset, sck_o is at the idle level selected by sample_fall_i, ready_n_o is 1, irq_o is 0 and rx_data_o is 0.
- R2: The shift-clock idle level equals sample_fall_i: 0 means idle low with sampling on the rising edge, and 1 means idle high with sampling on the falling edge. After halt_i is sampled low, sck_o leaves idle on the (HALF_DIV+1)-th clock. Each bit period is HALF_DIV cycles idle followed by HALF_DIV cycles active.
- R3: sd_i is sampled on the idle-to-active edge of sck_o. The first bit sampled becomes bit 7 of the word, and later bits fill the lower positions in order.
- R4: On the active-to-idle edge that ends the eighth bit, an empty buffer takes the word and ready_n_o drops to 0. irq_o pulses high for exactly one cycle with that load when irq_en_i is 1. It stays 0 when irq_en_i is 0.
- R5: The next word starts immediately. When the buffer has been read in time, consecutive loads are exactly 16*HALF_DIV cycles apart.
- R6: If the buffer is still full when a word completes, sck_o stays at idle and rx_data_o keeps the unread word. The new word is held, not lost.
- R7: A rd_i pulse while ready_n_o is 0 sets ready_n_o to 1 on the next cycle. A held word is loaded on the cycle after that, and the shift clock then resumes.
- R8: Raising halt_i during a word returns sck_o to idle on the next cycle. If n of 1 to 7 bits have been sampled, the buffer receives them in bits 7 down to 8-n with zeros below, and ready_n_o drops to 0. If no bit has been sampled, the buffer and ready flag are left unchanged.
- R9: Raising halt_i while a completed word is held overwrites the buffer with that word, even if the buffer was unread.
- R10: While halt_i is 1, sck_o stays at idle. The next activation restarts at bit 0 of a fresh word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | 1 stops reception (and terminates a word in progress); 0 runs it |
| sample_fall_i | input | 1 | Shift-clock polarity: 0 idle low / sample on rising, 1 idle high / sample on falling |
| sd_i | input | 1 | Serial data line |
| sck_o | output | 1 | Generated shift clock |
| rd_i | input | 1 | Host read strobe, one cycle, empties the buffer |
| irq_en_i | input | 1 | Enables the load interrupt pulse |
| rx_data_o | output | 8 | Receive buffer contents |
| ready_n_o | output | 1 | 0 while the buffer holds unread data |
| irq_o | output | 1 | One-cycle pulse when the buffer is loaded and irq_en_i is 1 |

## Verification
The bound assertions check, on every cycle, several properties. A full buffer is never rewritten unless the host reads it or halt is raised. The clock sits at idle throughout a stall, and a stall persists until a read or a halt. Halt forces the clock to idle one cycle later. The interrupt only appears alongside a full buffer when it was enabled. Exact bit order, the left alignment of a short word, the gap-free spacing of words and the hand-over of a held word after a read depend on data and sequence. Only the bench's scenarios show these, with a behavioural reference model compared against every output each cycle.

// File: rtl/sync_rx_pkg.sv
`timescale 1ns/1ps
package sync_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_RUN  = 2'd1,
    RX_HOLD = 2'd2
  } rx_state_e;
endpackage

// File: rtl/sync_rx_clkdiv.sv
`timescale 1ns/1ps
// Shift-clock phase generator: HALF_DIV system cycles per half period.
module sync_rx_clkdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  output logic phase_o,
  output logic lead_o,
  output logic trail_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] div_q, div_d;
  logic          ph_q, ph_d;
  logic          wrap;

  assign wrap    = (div_q == LAST);
  assign lead_o  = run_i && wrap && !ph_q;
  assign trail_o = run_i && wrap && ph_q;
  assign phase_o = ph_q;

  always_comb begin
    div_d = div_q;
    ph_d  = ph_q;
    if (restart_i) begin
      div_d = '0;
      ph_d  = 1'b0;
    end else if (run_i) begin
      if (wrap) begin
        div_d = '0;
        ph_d  = ~ph_q;
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      div_q <= div_d;
      ph_q  <= ph_d;
    end
  end
endmodule

// File: rtl/sync_rx_shifter.sv
`timescale 1ns/1ps
// MSB-first input shift register with bit counter and short-word alignment.
module sync_rx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         cnt_clr_i,
  input  logic         sample_i,
  input  logic         advance_i,
  input  logic         phase_i,
  input  logic         sd_i,
  output logic [W-1:0] shreg_o,
  output logic [W-1:0] aligned_o,
  output logic         last_o,
  output logic         any_o
);
  localparam int BCW = $clog2(W);
  localparam logic [BCW-1:0] LASTBIT = BCW'(W - 1);
  localparam logic [BCW:0]   WL      = (BCW+1)'(W);

  logic [W-1:0]   sh_q, sh_d;
  logic [BCW-1:0] cnt_q, cnt_d;
  logic [BCW:0]   nsamp;

  assign last_o    = (cnt_q == LASTBIT);
  assign nsamp     = {1'b0, cnt_q} + {{BCW{1'b0}}, phase_i};
  assign any_o     = (nsamp != '0);
  assign aligned_o = sh_q << (WL - nsamp);
  assign shreg_o   = sh_q;

  always_comb begin
    sh_d = sh_q;
    if (clr_i) begin
      sh_d = '0;
    end else if (sample_i) begin
      sh_d = {sh_q[W-2:0], sd_i};
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || cnt_clr_i) begin
      cnt_d = '0;
    end else if (advance_i && !last_o) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/sync_rx_buffer.sv
`timescale 1ns/1ps
// Single-entry receive buffer with active-low ready flag and interrupt pulse.
module sync_rx_buffer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         rd_i,
  input  logic         irq_en_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         irq_o
);
  logic [W-1:0] buf_q, buf_d;
  logic         full_q, full_d;
  logic         irq_q, irq_d;

  always_comb begin
    buf_d  = buf_q;
    full_d = full_q;
    irq_d  = 1'b0;
    if (load_i) begin
      buf_d  = data_i;
      full_d = 1'b1;
      irq_d  = irq_en_i;
    end else if (rd_i) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      full_q <= full_d;
      irq_q  <= irq_d;
    end
  end

  assign data_o = buf_q;
  assign full_o = full_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/sync_rx_stall.sv
`timescale 1ns/1ps
module sync_rx_stall #(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_i,
  input  logic              sample_fall_i,
  input  logic              sd_i,
  output logic              sck_o,
  input  logic              rd_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              ready_n_o,
  output logic              irq_o
);
  import sync_rx_pkg::*;

  rx_state_e         state_q, state_d;
  logic              restart, run_en, phase, lead, trail;
  logic              sh_clr, cnt_clr, last_bit, any_bit;
  logic              load;
  logic [DATA_W-1:0] shreg, aligned, ld_data;
  logic              full;
  logic              hold_w;

  assign run_en = (state_q == RX_RUN) && !halt_i;
  assign hold_w = (state_q == RX_HOLD);

  sync_rx_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .run_i     (run_en),
    .phase_o   (phase),
    .lead_o    (lead),
    .trail_o   (trail)
  );

  sync_rx_shifter #(.W(DATA_W)) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (sh_clr),
    .cnt_clr_i (cnt_clr),
    .sample_i  (lead),
    .advance_i (trail),
    .phase_i   (phase),
    .sd_i      (sd_i),
    .shreg_o   (shreg),
    .aligned_o (aligned),
    .last_o    (last_bit),
    .any_o     (any_bit)
  );

  sync_rx_buffer #(.W(DATA_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .data_i   (ld_data),
    .rd_i     (rd_i),
    .irq_en_i (irq_en_i),
    .data_o   (rx_data_o),
    .full_o   (full),
    .irq_o    (irq_o)
  );

  // Control: next state and buffer transfers
  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    sh_clr  = 1'b0;
    cnt_clr = 1'b0;
    load    = 1'b0;
    ld_data = shreg;
    unique case (state_q)
      RX_IDLE: begin
        if (!halt_i) begin
          state_d = RX_RUN;
          restart = 1'b1;
          sh_clr  = 1'b1;
        end
      end
      RX_RUN: begin
        if (halt_i) begin
          state_d = RX_IDLE;
          if (any_bit) begin
            load    = 1'b1;
            ld_data = aligned;
          end
        end else if (trail && last_bit) begin
          if (!full) begin
            load    = 1'b1;
            cnt_clr = 1'b1;
          end else begin
            state_d = RX_HOLD;
          end
        end
      end
      RX_HOLD: begin
        if (halt_i) begin
          state_d = RX_IDLE;
          load    = 1'b1;
        end else if (!full) begin
          state_d = RX_RUN;
          load    = 1'b1;
          cnt_clr = 1'b1;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign sck_o     = sample_fall_i ^ ((state_q == RX_RUN) && phase);
  assign ready_n_o = ~full;
endmodule

module sync_rx_stall_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halt_i,
  input logic              sample_fall_i,
  input logic              rd_i,
  input logic              irq_en_i,
  input logic              sck_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              ready_n_o,
  input logic              irq_o,
  input logic              hold_i
);
  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready_n_o && !rd_i && !halt_i) |=> $stable(rx_data_o));

  assert_hold_clock_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> (sck_o == sample_fall_i));

  assert_hold_persists_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !ready_n_o && !rd_i && !halt_i) |=> hold_i);

  assert_halt_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> (sck_o == sample_fall_i));

  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (!ready_n_o && $past(irq_en_i)));
endmodule

bind sync_rx_stall sync_rx_stall_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .halt_i        (halt_i),
  .sample_fall_i (sample_fall_i),
  .rd_i          (rd_i),
  .irq_en_i      (irq_en_i),
  .sck_o         (sck_o),
  .rx_data_o     (rx_data_o),
  .ready_n_o     (ready_n_o),
  .irq_o         (irq_o),
  .hold_i        (hold_w)
);

// File: tb/sync_rx_stall_tb.sv
`timescale 1ns/1ps
module sync_rx_stall_tb_top;
  localparam int H = 3;

  logic       clk, rst_n, halt_i, sample_fall_i, sd_i, rd_i, irq_en_i;
  logic       sck_o, ready_n_o, irq_o;
  logic [7:0] rx_data_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int irq_seen = 0;
  bit done = 0;

  sync_rx_stall #(.DATA_W(8), .HALF_DIV(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .sample_fall_i(sample_fall_i),
    .sd_i(sd_i), .sck_o(sck_o), .rd_i(rd_i), .irq_en_i(irq_en_i),
    .rx_data_o(rx_data_o), .ready_n_o(ready_n_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 181) & 255);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model (0 idle, 1 running, 2 holding)
  int m_state, m_div, m_ph, m_bits, m_sh, m_full, m_buf, m_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_div = 0; m_ph = 0; m_bits = 0;
      m_sh = 0; m_full = 0; m_buf = 0; m_irq = 0;
    end else begin
      int ld, ldv, n;
      ld = 0; ldv = 0;
      if (m_state == 0) begin
        if (!halt_i) begin
          m_state = 1; m_div = 0; m_ph = 0; m_bits = 0; m_sh = 0;
        end
      end else if (m_state == 1) begin
        if (halt_i) begin
          n = m_bits + m_ph;
          if (n > 0) begin ld = 1; ldv = (m_sh << (8 - n)) & 255; end
          m_state = 0;
        end else if (m_div == H - 1) begin
          m_div = 0;
          if (m_ph == 0) begin
            m_ph = 1; m_sh = ((m_sh << 1) | int'(sd_i)) & 255;
          end else begin
            m_ph = 0;
            if (m_bits == 7) begin
              if (m_full == 0) begin ld = 1; ldv = m_sh; m_bits = 0; end
              else m_state = 2;
            end else m_bits++;
          end
        end else m_div++;
      end else begin
        if (halt_i) begin ld = 1; ldv = m_sh; m_state = 0; end
        else if (m_full == 0) begin ld = 1; ldv = m_sh; m_bits = 0; m_state = 1; m_div = 0; end
      end
      if (ld) begin m_full = 1; m_buf = ldv; m_irq = int'(irq_en_i); end
      else begin m_irq = 0; if (rd_i) m_full = 0; end
    end
  end

  // Per-cycle comparison against the model, plus watchdog
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (irq_o) irq_seen++;
      check(sck_o == (sample_fall_i ^ (m_state == 1 && m_ph == 1)), "R2 model sck",
            int'(sck_o), int'(sample_fall_i ^ (m_state == 1 && m_ph == 1)));
      check(ready_n_o == (m_full == 0), "R4 model ready_n", int'(ready_n_o), int'(m_full == 0));
      check(irq_o == (m_irq != 0), "R4 model irq", int'(irq_o), m_irq);
      check(int'(rx_data_o) == m_buf, "R3 model buffer", int'(rx_data_o), m_buf);
      if (cyc == 100000) begin
        check(1'b0, "watchdog expired", cyc, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  // Serial data source: changes only after the active-to-idle edge
  always @(negedge clk) begin
    static int k = 0;
    static int b = 0;
    static bit prev_act = 0;
    bit act;
    logic [7:0] w;
    act = (sck_o != sample_fall_i);
    if (!rst_n || halt_i) begin
      k = 0; b = 0;
    end else if (prev_act && !act) begin
      b++;
      if (b == 8) begin b = 0; k++; end
    end
    prev_act = act;
    w = pat(k);
    sd_i <= w[7 - b];
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready(input string tag);
    for (int i = 0; i < 2000; i++) begin
      if (!ready_n_o) return;
      @(negedge clk);
    end
    check(1'b0, tag, 1, 0);
  endtask

  task automatic read_pulse();
    rd_i <= 1'b1;
    @(negedge clk);
    rd_i <= 1'b0;
  endtask

  function automatic bit active();
    return sck_o != sample_fall_i;
  endfunction

  initial begin
    int c, t0, leads, irq0;
    bit stuck;
    rst_n = 1'b0; halt_i = 1'b1; sample_fall_i = 1'b0;
    irq_en_i = 1'b1; rd_i = 1'b0;
    tick(3);
    // R1 reset state
    check(sck_o == 1'b0, "R1 sck idle", int'(sck_o), 0);
    check(ready_n_o == 1'b1, "R1 ready_n", int'(ready_n_o), 1);
    check(irq_o == 1'b0, "R1 irq", int'(irq_o), 0);
    check(rx_data_o == 8'h00, "R1 buffer", int'(rx_data_o), 0);
    rst_n <= 1'b1;
    tick(2);

    // R2 clock timing after activation
    halt_i <= 1'b0;
    c = 0;
    do begin @(negedge clk); c++; end while (!active() && c < 100);
    check(c == H + 1, "R2 first active edge delay", c, H + 1);
    c = 0;
    while (active() && c < 100) begin @(negedge clk); c++; end
    check(c == H, "R2 active half length", c, H);

    // R3/R4 first word
    wait_ready("R4 first word never loaded");
    t0 = cyc;
    check(rx_data_o == pat(0), "R3 first word MSB first", int'(rx_data_o), int'(pat(0)));
    read_pulse();
    check(ready_n_o == 1'b1, "R7 ready_n after read", int'(ready_n_o), 1);

    // R5 gap-free second word
    wait_ready("R5 second word never loaded");
    check(cyc - t0 == 16 * H, "R5 word spacing", cyc - t0, 16 * H);
    check(rx_data_o == pat(1), "R5 second word", int'(rx_data_o), int'(pat(1)));
    tick(1);
    check(irq_seen == 2, "R4 irq pulses enabled", irq_seen, 2);

    // R6 stall: leave word 1 unread
    tick(16 * H + 4);
    stuck = 1;
    for (int i = 0; i < 20 * H; i++) begin
      if (active()) stuck = 0;
      @(negedge clk);
    end
    check(stuck, "R6 clock idle while held", int'(stuck), 1);
    check(rx_data_o == pat(1), "R6 buffer kept", int'(rx_data_o), int'(pat(1)));

    // R7 read releases the held word
    read_pulse();
    check(ready_n_o == 1'b1, "R7 ready_n cleared", int'(ready_n_o), 1);
    @(negedge clk);
    check(ready_n_o == 1'b0, "R7 held word loaded", int'(ready_n_o), 0);
    check(rx_data_o == pat(2), "R7 held word value", int'(rx_data_o), int'(pat(2)));
    c = 0;
    while (!active() && c < 100) begin @(negedge clk); c++; end
    check(active(), "R7 clock resumes", int'(active()), 1);
    read_pulse();
    wait_ready("R5 word after resume");
    check(rx_data_o == pat(3), "R5 word after resume", int'(rx_data_o), int'(pat(3)));
    read_pulse();

    // R8 partial word: halt after three sampled bits of word 4
    leads = 0;
    begin
      bit pa;
      pa = active();
      for (int i = 0; i < 500 && leads < 3; i++) begin
        @(negedge clk);
        if (active() && !pa) leads++;
        pa = active();
      end
    end
    halt_i <= 1'b1;
    tick(2);
    check(!active(), "R8 clock idle after halt", int'(active()), 0);
    check(ready_n_o == 1'b0, "R8 partial word flagged", int'(ready_n_o), 0);
    check(rx_data_o == (pat(4) & 8'hE0), "R8 partial word aligned",
          int'(rx_data_o), int'(pat(4) & 8'hE0));

    // R8 halt before any bit: buffer untouched
    read_pulse();
    halt_i <= 1'b0;
    @(negedge clk);
    halt_i <= 1'b1;
    tick(3);
    check(ready_n_o == 1'b1, "R8 empty halt no load", int'(ready_n_o), 1);
    check(rx_data_o == (pat(4) & 8'hE0), "R8 empty halt buffer",
          int'(rx_data_o), int'(pat(4) & 8'hE0));

    // R2/R4/R9/R10 opposite polarity, no interrupt, halt while held
    sample_fall_i <= 1'b1;
    irq_en_i <= 1'b0;
    tick(2);
    check(sck_o == 1'b1, "R2 idle high polarity", int'(sck_o), 1);
    irq0 = irq_seen;
    halt_i <= 1'b0;
    wait_ready("R10 restart first word");
    check(rx_data_o == pat(0), "R10 restart from bit 0", int'(rx_data_o), int'(pat(0)));
    tick(20 * H);
    check(rx_data_o == pat(0), "R6 unread kept", int'(rx_data_o), int'(pat(0)));
    halt_i <= 1'b1;
    tick(2);
    check(rx_data_o == pat(1), "R9 held word overwrites", int'(rx_data_o), int'(pat(1)));
    check(ready_n_o == 1'b0, "R9 ready_n", int'(ready_n_o), 0);
    check(irq_seen == irq0, "R4 irq disabled", irq_seen - irq0, 0);
    stuck = 1;
    for (int i = 0; i < 10 * H; i++) begin
      if (active()) stuck = 0;
      @(negedge clk);
    end
    check(stuck, "R10 no clock while halted", int'(stuck), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule